// File: doc/BRIEF.md
# Vertex Index Reuse Cache

This block walks the vertices of one draw in order and, for each one, works out a vertex id. It then decides whether that id was already processed earlier in the same draw. For a plain draw the id is a running loop counter added to a start offset. For an indexed draw the id is read from an index array in memory, one byte or one 16-bit little-endian halfword per vertex, through a request/response fetch port.

Ids from an indexed draw are looked up in a 32-entry fully associative store that holds the processed payloads. A hit hands back the stored payload without asking the external vertex processor. A miss sends the id to the processor through a request/response port. The returned payload is then written into the slot named by a circular insert pointer. Every draw starts with an empty store. The all-ones id is reserved as a restart marker: it raises an error pulse, it is still processed, and it is never placed in the store.

Results leave on a valid/ready stream, one beat per vertex and in draw order. Each beat carries the id, the payload, a hit marker and an end-of-draw marker. A new draw command is accepted only while the block is idle.

Top module: `vtx_reuse_cache`

## Requirements
- R1: After reset the block is idle: `start_ready` is 1 and `fetch_valid`, `proc_valid`, `out_valid` and `bad_vid` are 0.
- R2: In a non-indexed draw, vertex i gets id `(start_offset + i) mod 2^16`. No fetch is issued, every vertex is sent to the processor, and `out_hit` is 0 on every beat.
- R3: In an indexed draw, vertex i fetches from `start_base + i` when `start_wide` is 0, or from `start_base + 2*i` when `start_wide` is 1. With `start_wide` = 1 the id is all 16 bits of `fetch_rsp_data`. With `start_wide` = 0 the id is `fetch_rsp_data[7:0]` zero-extended, and the upper byte is ignored. `start_offset` has no effect on an indexed draw.
- R4: In an indexed draw, an id that is still held in the store is not sent to the processor. Its beat has `out_hit` = 1 and carries the payload stored when that id missed.
- R5: Each indexed miss of a legal id writes its payload at the insert pointer, and the pointer then advances modulo 32. The 33rd distinct id of a draw therefore evicts the first one, and a later access to the evicted id misses.
- R6: Accepting a draw command sets every tag to all-ones and the insert pointer to 0, so an id cached by an earlier draw misses on its first use in the new draw.
- R7: A vertex whose id is 16'hFFFF raises `bad_vid` for exactly one cycle. It is sent to the processor and is never inserted or matched. In 8-bit mode, byte 0xFF becomes id 0x00FF and is legal.
- R8: Exactly `start_count` beats are produced, in draw order. `out_last` is 1 only on the final beat. While `out_valid` is 1 and `out_ready` is 0, the beat's fields hold steady.
- R9: A draw command with `start_count` = 0 is accepted, produces no beat and no request, and leaves the block idle on the next cycle.
- R10: `fetch_valid` and `proc_valid` stay high, with `fetch_addr` and `proc_vid` unchanged, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Draw command offered |
| start_ready | output | 1 | Block idle, command can be taken |
| start_count | input | CNT_W | Number of vertices in the draw |
| start_offset | input | VID_W | First id of a non-indexed draw |
| start_indexed | input | 1 | 1: ids come from the index array |
| start_wide | input | 1 | 1: 16-bit index entries, 0: 8-bit |
| start_base | input | ADDR_W | Byte address of the index array |
| fetch_valid | output | 1 | Index fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | ADDR_W | Byte address of the index entry |
| fetch_wide | output | 1 | Entry size of the request (1: two bytes) |
| fetch_rsp_valid | input | 1 | Fetch data returned |
| fetch_rsp_data | input | VID_W | Index entry, little-endian, low byte first |
| proc_valid | output | 1 | Vertex processing request |
| proc_ready | input | 1 | Processing request accepted |
| proc_vid | output | VID_W | Id to process |
| proc_rsp_valid | input | 1 | Processed payload returned |
| proc_rsp_payload | input | PAY_W | Processed payload |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_vid | output | VID_W | Id of the vertex |
| out_payload | output | PAY_W | Payload of the vertex |
| out_hit | output | 1 | Payload came from the store |
| out_last | output | 1 | Final vertex of the draw |
| bad_vid | output | 1 | One-cycle pulse for an all-ones id |

## Verification
The sweeps target eviction order and draw-start clearing. A pointer that failed to wrap, or a store that survived into the next draw, would return hits where misses are due, and the payload serial numbers would expose the wrong slot. Restart ids in both index widths, and a plain draw whose offset wraps through 16'hFFFF, catch a design that caches the marker, misses the pulse, or flags 8-bit 0xFF. Stalls on every handshake, together with a zero-length draw, show a design that drops, repeats or reorders beats, or that uses the offset or the upper fetch byte where it must not.

// File: rtl/vtx_cache_pkg.sv
// Shared types for the vertex index reuse cache.
package vtx_cache_pkg;

    // Per-vertex sequencing states of the controller.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_FREQ   = 3'd2,
        ST_FWAIT  = 3'd3,
        ST_LOOKUP = 3'd4,
        ST_PREQ   = 3'd5,
        ST_PWAIT  = 3'd6,
        ST_EMIT   = 3'd7
    } vc_state_e;

endpackage

// File: rtl/vtx_idx_addr.sv
// Index address and id generation.
// Purely combinational. Forms the byte address of index entry idx, the
// sequential id offset+idx, and the id decoded from a fetched entry.
// Assumes VID_W >= 8; the 8-bit format uses the low byte only.
module vtx_idx_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int VID_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VID_W-1:0]  offset,
    input  logic [CNT_W-1:0]  idx,
    input  logic              wide,
    input  logic [VID_W-1:0]  raw,
    output logic [ADDR_W-1:0] addr,
    output logic [VID_W-1:0]  seq_vid,
    output logic [VID_W-1:0]  idx_vid
);
    localparam int NARROW_W = 8;

    logic [ADDR_W-1:0] step;

    // Byte address: one or two bytes per entry.
    always_comb begin
        step = ADDR_W'(idx);
        addr = base + (wide ? {step[ADDR_W-2:0], 1'b0} : step);
    end

    // Non-indexed id wraps modulo 2^VID_W.
    assign seq_vid = offset + VID_W'(idx);

    generate
        if (VID_W > NARROW_W) begin : g_ext
            // Narrow entries are zero-extended; the upper bits of raw are dropped.
            assign idx_vid = wide ? raw : {{(VID_W-NARROW_W){1'b0}}, raw[NARROW_W-1:0]};
        end else begin : g_flat
            assign idx_vid = raw;
        end
    endgenerate

endmodule

// File: rtl/vtx_tag_store.sv
// Fully associative id/payload store with circular replacement.
// All tags are compared at once against look_vid; the all-ones id never
// matches. clear sets every tag to all-ones and the pointer to zero.
// ins_en writes at the pointer and advances it modulo ENTRIES.
// Assumes clear and ins_en are never high in the same cycle.
module vtx_tag_store #(
    parameter int ENTRIES = 32,
    parameter int VID_W   = 16,
    parameter int PAY_W   = 32,
    parameter int PTR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               ins_en,
    input  logic [VID_W-1:0]   ins_vid,
    input  logic [PAY_W-1:0]   ins_pay,
    input  logic [VID_W-1:0]   look_vid,
    output logic               hit,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [PAY_W-1:0]   hit_pay,
    output logic [PTR_W-1:0]   ptr
);
    localparam logic [VID_W-1:0] ONES    = '1;
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(ENTRIES - 1);

    logic [VID_W-1:0] tag_q [ENTRIES];
    logic [PAY_W-1:0] pay_q [ENTRIES];
    logic             look_ok;

    assign look_ok = (look_vid != ONES);

    // Tag array: reset and per-draw clear to all-ones, write at pointer on insert.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int e = 0; e < ENTRIES; e++) tag_q[e] <= ONES;
        end else if (ins_en) begin
            tag_q[ptr] <= ins_vid;
        end
    end

    // Payload array: written alongside its tag, no reset needed.
    always_ff @(posedge clk) begin
        if (ins_en) pay_q[ptr] <= ins_pay;
    end

    // Insert pointer: circular over ENTRIES slots.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (ins_en) begin
            ptr <= (ptr == PTR_TOP) ? '0 : ptr + 1'b1;
        end
    end

    // Parallel compare, one comparator per entry.
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign hit_vec[e] = look_ok && (tag_q[e] == look_vid);
        end
    endgenerate

    // Payload select by OR of masked entries (tags are unique within a draw).
    always_comb begin
        hit_pay = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            hit_pay = hit_pay | (pay_q[e] & {PAY_W{hit_vec[e]}});
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/vtx_seq_ctrl.sv
// Draw sequencer.
// Accepts a draw command when idle, then handles one vertex at a time:
// obtain id, look up (indexed only), process on miss, emit one beat.
// All handshakes are valid/ready; requests hold until accepted.
// Assumes the fetch and process responders return exactly one response
// per accepted request, in order.
module vtx_seq_ctrl
    import vtx_cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int VID_W  = 16,
    parameter int PAY_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [VID_W-1:0]  start_offset,
    input  logic              start_indexed,
    input  logic              start_wide,
    input  logic [ADDR_W-1:0] start_base,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    input  logic              fetch_rsp_valid,
    input  logic [VID_W-1:0]  fetch_vid,
    output logic              proc_valid,
    input  logic              proc_ready,
    input  logic              proc_rsp_valid,
    input  logic [PAY_W-1:0]  proc_rsp_payload,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PAY_W-1:0]  out_payload,
    output logic              out_hit,
    output logic              out_last,
    output logic              bad_vid,
    output logic              draw_indexed,
    output logic              draw_wide,
    output logic [ADDR_W-1:0] draw_base,
    output logic [VID_W-1:0]  draw_offset,
    output logic [CNT_W-1:0]  draw_idx,
    input  logic [VID_W-1:0]  seq_vid,
    output logic [VID_W-1:0]  cur_vid,
    output logic              tag_clear,
    output logic              tag_ins,
    input  logic              tag_hit,
    input  logic [PAY_W-1:0]  tag_pay
);
    localparam logic [VID_W-1:0] ONES = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    vc_state_e        state;
    logic [CNT_W-1:0] cnt_q;
    logic [PAY_W-1:0] pay_q;
    logic             hit_q;
    logic             cacheable_q;
    logic             bad_q;

    // Main sequencing FSM with per-vertex working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt_q        <= '0;
            draw_idx     <= '0;
            draw_indexed <= 1'b0;
            draw_wide    <= 1'b0;
            draw_base    <= '0;
            draw_offset  <= '0;
            cur_vid      <= '0;
            pay_q        <= '0;
            hit_q        <= 1'b0;
            cacheable_q  <= 1'b0;
            bad_q        <= 1'b0;
        end else begin
            bad_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_valid) begin
                        cnt_q        <= start_count;
                        draw_idx     <= '0;
                        draw_indexed <= start_indexed;
                        draw_wide    <= start_wide;
                        draw_base    <= start_base;
                        draw_offset  <= start_offset;
                        state        <= (start_count == '0) ? ST_IDLE : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    hit_q       <= 1'b0;
                    cacheable_q <= 1'b0;
                    if (draw_indexed) begin
                        state <= ST_FREQ;
                    end else begin
                        cur_vid <= seq_vid;
                        bad_q   <= (seq_vid == ONES);
                        state   <= ST_PREQ;
                    end
                end
                ST_FREQ: begin
                    if (fetch_ready) state <= ST_FWAIT;
                end
                ST_FWAIT: begin
                    if (fetch_rsp_valid) begin
                        cur_vid <= fetch_vid;
                        state   <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (cur_vid == ONES) begin
                        bad_q <= 1'b1;
                        state <= ST_PREQ;
                    end else if (tag_hit) begin
                        pay_q <= tag_pay;
                        hit_q <= 1'b1;
                        state <= ST_EMIT;
                    end else begin
                        cacheable_q <= 1'b1;
                        state       <= ST_PREQ;
                    end
                end
                ST_PREQ: begin
                    if (proc_ready) state <= ST_PWAIT;
                end
                ST_PWAIT: begin
                    if (proc_rsp_valid) begin
                        pay_q <= proc_rsp_payload;
                        state <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (out_last) begin
                            state <= ST_IDLE;
                        end else begin
                            draw_idx <= draw_idx + 1'b1;
                            state    <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake and store control decoded from state.
    assign start_ready = (state == ST_IDLE);
    assign tag_clear   = (state == ST_IDLE) && start_valid;
    assign fetch_valid = (state == ST_FREQ);
    assign proc_valid  = (state == ST_PREQ);
    assign tag_ins     = (state == ST_PWAIT) && proc_rsp_valid && cacheable_q;
    assign out_valid   = (state == ST_EMIT);
    assign out_payload = pay_q;
    assign out_hit     = hit_q;
    assign out_last    = (draw_idx == cnt_q - ONE);
    assign bad_vid     = bad_q;

endmodule

// File: rtl/vtx_reuse_cache.sv
// Vertex index reuse cache, top level.
// Joins the id generator, the sequencer and the 32-entry store.
// Only indexed draws look up or fill the store; each draw starts clean.
module vtx_reuse_cache #(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int VID_W   = 16,
    parameter int PAY_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [VID_W-1:0]  start_offset,
    input  logic              start_indexed,
    input  logic              start_wide,
    input  logic [ADDR_W-1:0] start_base,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_wide,
    input  logic              fetch_rsp_valid,
    input  logic [VID_W-1:0]  fetch_rsp_data,
    output logic              proc_valid,
    input  logic              proc_ready,
    output logic [VID_W-1:0]  proc_vid,
    input  logic              proc_rsp_valid,
    input  logic [PAY_W-1:0]  proc_rsp_payload,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VID_W-1:0]  out_vid,
    output logic [PAY_W-1:0]  out_payload,
    output logic              out_hit,
    output logic              out_last,
    output logic              bad_vid
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic              draw_indexed;
    logic              draw_wide;
    logic [ADDR_W-1:0] draw_base;
    logic [VID_W-1:0]  draw_offset;
    logic [CNT_W-1:0]  draw_idx;
    logic [VID_W-1:0]  seq_vid;
    logic [VID_W-1:0]  idx_vid;
    logic [VID_W-1:0]  cur_vid;
    logic              tag_clear;
    logic              tag_ins;
    logic              tag_hit;
    logic [PAY_W-1:0]  tag_pay;
    logic [ENTRIES-1:0] hit_vec;
    logic [PTR_W-1:0]  ins_ptr;

    vtx_idx_addr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .VID_W  (VID_W)
    ) u_addr (
        .base    (draw_base),
        .offset  (draw_offset),
        .idx     (draw_idx),
        .wide    (draw_wide),
        .raw     (fetch_rsp_data),
        .addr    (fetch_addr),
        .seq_vid (seq_vid),
        .idx_vid (idx_vid)
    );

    vtx_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .VID_W  (VID_W),
        .PAY_W  (PAY_W)
    ) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_valid      (start_valid),
        .start_ready      (start_ready),
        .start_count      (start_count),
        .start_offset     (start_offset),
        .start_indexed    (start_indexed),
        .start_wide       (start_wide),
        .start_base       (start_base),
        .fetch_valid      (fetch_valid),
        .fetch_ready      (fetch_ready),
        .fetch_rsp_valid  (fetch_rsp_valid),
        .fetch_vid        (idx_vid),
        .proc_valid       (proc_valid),
        .proc_ready       (proc_ready),
        .proc_rsp_valid   (proc_rsp_valid),
        .proc_rsp_payload (proc_rsp_payload),
        .out_valid        (out_valid),
        .out_ready        (out_ready),
        .out_payload      (out_payload),
        .out_hit          (out_hit),
        .out_last         (out_last),
        .bad_vid          (bad_vid),
        .draw_indexed     (draw_indexed),
        .draw_wide        (draw_wide),
        .draw_base        (draw_base),
        .draw_offset      (draw_offset),
        .draw_idx         (draw_idx),
        .seq_vid          (seq_vid),
        .cur_vid          (cur_vid),
        .tag_clear        (tag_clear),
        .tag_ins          (tag_ins),
        .tag_hit          (tag_hit),
        .tag_pay          (tag_pay)
    );

    vtx_tag_store #(
        .ENTRIES (ENTRIES),
        .VID_W   (VID_W),
        .PAY_W   (PAY_W),
        .PTR_W   (PTR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tag_clear),
        .ins_en   (tag_ins),
        .ins_vid  (cur_vid),
        .ins_pay  (proc_rsp_payload),
        .look_vid (cur_vid),
        .hit      (tag_hit),
        .hit_vec  (hit_vec),
        .hit_pay  (tag_pay),
        .ptr      (ins_ptr)
    );

    // Request sideband follows the latched draw and current vertex.
    assign fetch_wide = draw_wide;
    assign proc_vid   = cur_vid;
    assign out_vid    = cur_vid;

endmodule

// File: rtl/vtx_reuse_cache_chk.sv
// Protocol and store checks for vtx_reuse_cache, attached by bind.
module vtx_reuse_cache_chk #(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int VID_W   = 16,
    parameter int PAY_W   = 32,
    parameter int PTR_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_valid,
    input logic               start_ready,
    input logic [CNT_W-1:0]   start_count,
    input logic               fetch_valid,
    input logic               fetch_ready,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic               proc_valid,
    input logic               proc_ready,
    input logic [VID_W-1:0]   proc_vid,
    input logic               out_valid,
    input logic               out_ready,
    input logic [VID_W-1:0]   out_vid,
    input logic [PAY_W-1:0]   out_payload,
    input logic               out_hit,
    input logic               bad_vid,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [PTR_W-1:0]   ins_ptr,
    input logic               draw_indexed
);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_vid) && $stable(out_hit));

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

    // R10
    proc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_valid && !proc_ready |=> proc_valid && $stable(proc_vid));

    // R6
    clear_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && start_ready |=> ins_ptr == '0);

    // R4
    unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R2
    seq_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !draw_indexed |-> !out_hit);

    // R7
    bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_vid |=> !bad_vid);

    // R9
    empty_draw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && start_ready && (start_count == '0) |=> start_ready && !fetch_valid && !proc_valid);

endmodule

bind vtx_reuse_cache vtx_reuse_cache_chk #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .VID_W   (VID_W),
    .PAY_W   (PAY_W),
    .PTR_W   (PTR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_valid  (start_valid),
    .start_ready  (start_ready),
    .start_count  (start_count),
    .fetch_valid  (fetch_valid),
    .fetch_ready  (fetch_ready),
    .fetch_addr   (fetch_addr),
    .proc_valid   (proc_valid),
    .proc_ready   (proc_ready),
    .proc_vid     (proc_vid),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_vid      (out_vid),
    .out_payload  (out_payload),
    .out_hit      (out_hit),
    .bad_vid      (bad_vid),
    .hit_vec      (hit_vec),
    .ins_ptr      (ins_ptr),
    .draw_indexed (draw_indexed)
);

// File: tb/vtx_reuse_cache_test.sv
`timescale 1ns/1ps
module vtx_reuse_cache_test;
    localparam int ENTRIES = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [15:0] start_count = '0;
    logic [15:0] start_offset = '0;
    logic        start_indexed = 1'b0;
    logic        start_wide = 1'b0;
    logic [31:0] start_base = '0;
    logic        fetch_valid;
    logic        fetch_ready = 1'b1;
    logic [31:0] fetch_addr;
    logic        fetch_wide;
    logic        fetch_rsp_valid = 1'b0;
    logic [15:0] fetch_rsp_data = '0;
    logic        proc_valid;
    logic        proc_ready = 1'b1;
    logic [15:0] proc_vid;
    logic        proc_rsp_valid = 1'b0;
    logic [31:0] proc_rsp_payload = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_vid;
    logic [31:0] out_payload;
    logic        out_hit;
    logic        out_last;
    logic        bad_vid;

    always #2 clk = ~clk;

    vtx_reuse_cache uut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  mem [0:1023];
    logic [15:0] e_vid [0:255];
    logic        e_hit [0:255];
    logic [31:0] e_pay [0:255];
    int exp_n = 0, got_n = 0;
    int exp_bad = 0, bad_seen = 0, exp_proc = 0, proc_seen = 0;
    int serial_model = 0, serial_rsp = 0;
    int fidx = 0;
    logic [31:0] d_base = '0;
    logic        d_wide = 1'b0;
    logic [15:0] m_tag [0:ENTRIES-1];
    logic [31:0] m_pay [0:ENTRIES-1];
    int m_ptr = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_idx(input int base, input int i, input bit wd);
        int a;
        a = wd ? base + 2 * i : base + i;
        return wd ? {mem[(a + 1) & 1023], mem[a & 1023]} : {8'h00, mem[a & 1023]};
    endfunction

    // Cycle counter for stall patterns.
    always @(negedge clk) cyc <= cyc + 1;

    // Output monitor: pick ready first, then judge the beat taken at the next edge.
    always @(negedge clk) begin
        out_ready = ((cyc % 4) != 3);
        if (out_valid && out_ready) begin
            if (got_n >= exp_n) begin
                check(1'b0, "R8", "extra beat", 64'(out_vid), 64'hFFFF_FFFF);
            end else begin
                // R2 R4 R5 R6 R8: id, hit flag, payload and last marker
                check(out_vid == e_vid[got_n] && out_hit == e_hit[got_n] &&
                      out_payload == e_pay[got_n] && out_last == (got_n == exp_n - 1),
                      "R4/R5/R8", "beat {last,hit,vid,payload}",
                      {out_last, out_hit, 14'd0, out_vid, out_payload},
                      {(got_n == exp_n - 1) ? 1'b1 : 1'b0, e_hit[got_n], 14'd0, e_vid[got_n], e_pay[got_n]});
            end
            got_n++;
        end
        if (bad_vid) bad_seen++;
    end

    // Fetch responder with stalls; also checks addresses and request hold.
    logic f_pend = 1'b0;
    logic [31:0] f_addr = '0;
    logic f_stalled = 1'b0;
    logic [31:0] f_prev = '0;
    always @(negedge clk) begin
        if (fetch_rsp_valid) fetch_rsp_valid = 1'b0;
        if (f_pend) begin
            fetch_rsp_valid = 1'b1;
            fetch_rsp_data  = d_wide ? {mem[(f_addr + 1) & 1023], mem[f_addr & 1023]}
                                     : {8'hEE, mem[f_addr & 1023]};
            f_pend = 1'b0;
        end
        if (f_stalled) begin
            // R10 fetch request held after a refused cycle
            check(fetch_valid && fetch_addr == f_prev, "R10", "fetch hold", 64'(fetch_addr), 64'(f_prev));
        end
        fetch_ready = ((cyc % 3) != 1);
        f_stalled = fetch_valid && !fetch_ready;
        f_prev = fetch_addr;
        if (fetch_valid && fetch_ready) begin
            // R3 index entry address
            check(fetch_addr == d_base + (d_wide ? 2 * fidx : fidx) && fetch_wide == d_wide,
                  "R3", "fetch address", 64'(fetch_addr), 64'(d_base + (d_wide ? 2 * fidx : fidx)));
            f_addr = fetch_addr;
            f_pend = 1'b1;
            fidx++;
        end
    end

    // Process responder: variable latency, payload = {serial, id}.
    logic p_pend = 1'b0;
    int   p_dly = 0;
    logic [15:0] p_vid = '0;
    logic p_stalled = 1'b0;
    logic [15:0] p_prev = '0;
    always @(negedge clk) begin
        if (proc_rsp_valid) proc_rsp_valid = 1'b0;
        if (p_pend) begin
            if (p_dly == 0) begin
                proc_rsp_valid   = 1'b1;
                proc_rsp_payload = {serial_rsp[15:0], p_vid};
                serial_rsp++;
                p_pend = 1'b0;
            end else begin
                p_dly--;
            end
        end
        if (p_stalled) begin
            // R10 process request held after a refused cycle
            check(proc_valid && proc_vid == p_prev, "R10", "proc hold", 64'(proc_vid), 64'(p_prev));
        end
        proc_ready = ((cyc % 5) != 2);
        p_stalled = proc_valid && !proc_ready;
        p_prev = proc_vid;
        if (proc_valid && proc_ready) begin
            p_vid  = proc_vid;
            p_dly  = int'(proc_vid % 3);
            p_pend = 1'b1;
            proc_seen++;
        end
    end

    // Run one draw: predict every beat, issue the command, wait, compare totals.
    task automatic run_draw(input int cnt, input int off, input bit ix, input bit wd, input int base);
        logic [15:0] vid;
        logic [31:0] pay;
        bit hit, bad;
        for (int k = 0; k < ENTRIES; k++) m_tag[k] = 16'hFFFF;
        m_ptr = 0;
        exp_n = cnt; got_n = 0; exp_bad = 0; bad_seen = 0; exp_proc = 0; proc_seen = 0; fidx = 0;
        d_base = 32'(base); d_wide = wd;
        for (int i = 0; i < cnt; i++) begin
            vid = ix ? rd_idx(base, i, wd) : 16'(off + i);
            bad = (vid == 16'hFFFF);
            hit = 1'b0;
            pay = '0;
            if (ix && !bad) begin
                for (int k = 0; k < ENTRIES; k++) begin
                    if (m_tag[k] == vid) begin hit = 1'b1; pay = m_pay[k]; end
                end
            end
            if (!hit) begin
                pay = {serial_model[15:0], vid};
                serial_model++;
                exp_proc++;
                if (ix && !bad) begin
                    m_tag[m_ptr] = vid; m_pay[m_ptr] = pay;
                    m_ptr = (m_ptr + 1) % ENTRIES;
                end
            end
            if (bad) exp_bad++;
            e_vid[i] = vid; e_hit[i] = hit; e_pay[i] = pay;
        end
        @(negedge clk);
        start_valid = 1'b1; start_count = 16'(cnt); start_offset = 16'(off);
        start_indexed = ix; start_wide = wd; start_base = 32'(base);
        @(negedge clk);
        start_valid = 1'b0;
        while (got_n < exp_n) @(negedge clk);
        repeat (4) @(negedge clk);
        // R8 R9 block back to idle with the beat count right
        check(start_ready && got_n == exp_n, "R8/R9", "idle after draw", 64'(got_n), 64'(exp_n));
        // R7 restart pulses
        check(bad_seen == exp_bad, "R7", "restart pulses", 64'(bad_seen), 64'(exp_bad));
        // R4 R5 processing requests
        check(proc_seen == exp_proc, "R4/R5", "process requests", 64'(proc_seen), 64'(exp_proc));
        // R2 R3 fetch count
        check(fidx == (ix ? cnt : 0), "R2/R3", "fetch count", 64'(fidx), 64'(ix ? cnt : 0));
    endtask

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = 8'(a * 13 + 5);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(start_ready && !fetch_valid && !proc_valid && !out_valid && !bad_vid,
              "R1", "reset outputs", {59'd0, start_ready, fetch_valid, proc_valid, out_valid, bad_vid},
              64'h10);

        // R2 plain draw; offset used, no fetch, all processed
        run_draw(5, 100, 1'b0, 1'b0, 0);
        // R2 R7 plain draw wrapping through the restart id
        run_draw(3, 16'hFFFE, 1'b0, 1'b0, 0);
        // R2 several offsets
        for (int o = 0; o < 4; o++) run_draw(4, o * 4099, 1'b0, 1'b0, 0);

        // R3 R4 8-bit indexed with repeats; offset must not matter; 0xFF is legal
        begin
            int pat8 [8] = '{3, 5, 3, 255, 5, 5, 255, 3};
            for (int i = 0; i < 8; i++) mem[16 + i] = 8'(pat8[i]);
        end
        run_draw(8, 777, 1'b1, 1'b0, 16);

        // R3 R4 16-bit indexed with repeats
        begin
            int pat16 [6] = '{16'h1234, 16'h00AB, 16'h1234, 16'hAB00, 16'h00AB, 16'h1234};
            for (int i = 0; i < 6; i++) begin
                mem[256 + 2 * i] = 8'(pat16[i]);
                mem[257 + 2 * i] = 8'(pat16[i] >> 8);
            end
        end
        run_draw(6, 0, 1'b1, 1'b1, 256);

        // R5 eviction: ids 0..39, then 0..7 again, then 16..19
        for (int i = 0; i < 40; i++) mem[512 + i] = 8'(i);
        for (int i = 0; i < 8; i++)  mem[552 + i] = 8'(i);
        for (int i = 0; i < 4; i++)  mem[560 + i] = 8'(16 + i);
        run_draw(52, 0, 1'b1, 1'b0, 512);
        // R6 same array again: store must start empty
        run_draw(52, 0, 1'b1, 1'b0, 512);

        // R7 restart ids in a 16-bit draw
        begin
            int pat [5] = '{1, 16'hFFFF, 1, 16'hFFFF, 2};
            for (int i = 0; i < 5; i++) begin
                mem[768 + 2 * i] = 8'(pat[i]);
                mem[769 + 2 * i] = 8'(pat[i] >> 8);
            end
        end
        run_draw(5, 0, 1'b1, 1'b1, 768);

        // R9 empty draws, both kinds
        run_draw(0, 50, 1'b0, 1'b0, 0);
        run_draw(0, 0, 1'b1, 1'b1, 0);

        // R5 sweep: stride pattern over 40 ids and 200 vertices
        for (int i = 0; i < 200; i++) mem[i] = 8'((i * 7) % 40);
        run_draw(200, 0, 1'b1, 1'b0, 0);
        // R5 sweep with 16-bit entries and a 33-id rotation
        for (int i = 0; i < 120; i++) begin
            mem[2 * i]     = 8'((i % 33) + 3);
            mem[2 * i + 1] = 8'h40;
        end
        run_draw(120, 0, 1'b1, 1'b1, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d beats expected %0d", got_n, exp_n);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule